// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Reservation Lock

This block lets several bus managers share one subordinate port on a tightly coupled bus. Each request is offered with a VALID flag and accepted with a READY flag in the same cycle. The response comes back a fixed number of cycles (DLY) after acceptance, and it has no handshake of its own. When no reservation is held, the arbiter forwards the valid request from the manager with the lowest index. Only that manager sees the subordinate's READY. Every other manager is held off by a low READY.

A manager can send a lock flag with its request. When such a request is accepted, the arbiter is reserved for that manager. From then on, requests from other managers are ignored, including higher-priority ones, and this holds even while the owner sits idle. The reservation ends when the owner completes a transfer with the lock flag clear. This supports read-modify-write sequences to memory, two-beat accesses to data wider than the bus, and DMA bursts that must not be interleaved. Response data is steered back to the manager that issued the request by a DLY-deep history of grant indices; no transaction IDs are used.

Top module: `lockarb_top`

## Requirements
- R1: After reset the arbiter is unreserved. With no manager valid, `sub_vld` is 0, every bit of `mgr_rdy` is 0, and every manager's response slice is 0.
- R2: When unreserved, the valid manager with the lowest index (index 0 is highest priority) is forwarded. `sub_vld` is 1, and `sub_wen`, `sub_adr`, `sub_ben` and `sub_wdt` equal that manager's fields.
- R3: At most one bit of `mgr_rdy` is 1. A bit can be 1 only for the granted manager and only while `sub_rdy` is 1. All other managers see 0.
- R4: A request that is not accepted (`sub_rdy` 0) changes no reservation state. In particular, a stalled request carrying the lock flag does not reserve the arbiter.
- R5: An accepted request with its lock flag set reserves the arbiter for its manager. In the following cycles only that manager is granted, even while a higher-priority manager is valid.
- R6: While reserved and the owner is idle, `sub_vld` is 0 and only the owner's `mgr_rdy` bit can be 1. Other valid managers stay stalled.
- R7: An accepted request from the owner with the lock flag clear ends the reservation. From the next cycle fixed priority applies again.
- R8: For every accepted transfer, `sub_rdt` in the cycle DLY cycles later (DLY=1 by default) appears on the issuing manager's slice of `mgr_rdt`. Manager i's slice is bits [i*DW +: DW]. All other slices are 0.
- R9: In a cycle with no accepted transfer DLY cycles earlier, all slices of `mgr_rdt` are 0 whatever `sub_rdt` carries.
- R10: Back-to-back accepted transfers from different managers each route their response to their own manager, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgr_vld | input | MGR_N | Request valid per manager |
| mgr_lck | input | MGR_N | Lock flag sent with each manager's request |
| mgr_wen | input | MGR_N | Write enable per manager |
| mgr_adr | input | MGR_N*AW | Address per manager, manager i at [i*AW +: AW] |
| mgr_ben | input | MGR_N*BW | Byte enables per manager |
| mgr_wdt | input | MGR_N*DW | Write data per manager |
| mgr_rdy | output | MGR_N | Request ready per manager |
| mgr_rdt | output | MGR_N*DW | Response data per manager, zero when not addressed |
| sub_vld | output | 1 | Request valid toward the subordinate |
| sub_wen | output | 1 | Write enable toward the subordinate |
| sub_adr | output | AW | Address toward the subordinate |
| sub_ben | output | BW | Byte enables toward the subordinate |
| sub_wdt | output | DW | Write data toward the subordinate |
| sub_rdy | input | 1 | Subordinate ready |
| sub_rdt | input | DW | Subordinate response data, DLY cycles after acceptance |

## Verification
Requests are offered from single managers, from pairs and from all three at once. Only the lowest valid index may reach the subordinate, and its address and data must come through rather than a neighbour's. Lock requests are tried three ways: under backpressure, with the owner idle while a higher-priority manager waits, and with the owner's unlocked release. These separate a reservation that is taken on acceptance from one taken on the bare request. They also show whether the reservation survives idle cycles and whether it ends at the right transfer. Response routing is checked with back-to-back transfers from different managers, with stalled cycles and with idle cycles. Each response must land on exactly the slice of its issuer, and no slice may be filled when nothing was accepted.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_st_e;

endpackage

// File: rtl/lockarb_prio.sv
module lockarb_prio #(
    parameter int MGR_N = 3,
    localparam int IW   = (MGR_N > 1) ? $clog2(MGR_N) : 1
) (
    input  logic [MGR_N-1:0] req,
    output logic [MGR_N-1:0] pick_oh,
    output logic [IW-1:0]    pick_idx
);

    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        for (int i = MGR_N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_oh     = '0;
                pick_oh[i]  = 1'b1;
                pick_idx    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lockarb_lock.sv
module lockarb_lock
    import lockarb_pkg::*;
#(
    parameter int MGR_N = 3,
    localparam int IW   = (MGR_N > 1) ? $clog2(MGR_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MGR_N-1:0] pick_oh,
    input  logic [IW-1:0]    pick_idx,
    input  logic [MGR_N-1:0] req_lck,
    input  logic             xfer,
    output logic [MGR_N-1:0] gnt_oh,
    output logic [IW-1:0]    gnt_idx,
    output logic             gnt_lck,
    output logic             held
);

    typedef struct packed {
        lock_st_e        st;
        logic [IW-1:0]   owner;
    } lk_t;

    lk_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.st == LK_HELD) begin
            gnt_idx = state_q.owner;
            gnt_oh  = '0;
            for (int i = 0; i < MGR_N; i++) begin
                if (state_q.owner == IW'(i)) gnt_oh[i] = 1'b1;
            end
        end else begin
            gnt_idx = pick_idx;
            gnt_oh  = pick_oh;
        end
        gnt_lck = |(req_lck & gnt_oh);
        if (xfer) begin
            if (gnt_lck) begin
                state_d.st    = LK_HELD;
                state_d.owner = gnt_idx;
            end else begin
                state_d.st    = LK_FREE;
                state_d.owner = '0;
            end
        end
        held = (state_q.st == LK_HELD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{st: LK_FREE, owner: '0};
        else        state_q <= state_d;
    end

    // R4
    stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(state_q));

    // R5
    held_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && gnt_lck) |=> (held && gnt_idx == $past(gnt_idx)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !gnt_lck) |=> !held);

endmodule

// File: rtl/lockarb_route.sv
module lockarb_route #(
    parameter int MGR_N = 3,
    parameter int DW    = 32,
    parameter int DLY   = 1,
    localparam int IW   = (MGR_N > 1) ? $clog2(MGR_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [IW-1:0]     gnt_idx,
    input  logic [DW-1:0]     sub_rdt,
    output logic [MGR_N*DW-1:0] mgr_rdt
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } slot_t;

    slot_t             out_slot;
    logic [MGR_N-1:0]  dst_oh;

    generate
        if (DLY == 0) begin : g_direct
            assign out_slot = '{vld: xfer, idx: gnt_idx};
        end else begin : g_pipe
            slot_t [DLY-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = '{vld: xfer, idx: gnt_idx};
                for (int k = 1; k < DLY; k++) pipe_d[k] = pipe_q[k-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= pipe_d;
            end

            assign out_slot = pipe_q[DLY-1];
        end
    endgenerate

    generate
        for (genvar i = 0; i < MGR_N; i++) begin : g_dst
            assign dst_oh[i] = out_slot.vld && (out_slot.idx == IW'(i));
            assign mgr_rdt[i*DW +: DW] = dst_oh[i] ? sub_rdt : '0;
        end
    endgenerate

    // R8
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_oh));

    // R9
    route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_slot.vld |-> (mgr_rdt == '0));

endmodule

// File: rtl/lockarb_top.sv
module lockarb_top #(
    parameter int MGR_N = 3,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DLY   = 1,
    localparam int BW   = DW / 8,
    localparam int IW   = (MGR_N > 1) ? $clog2(MGR_N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MGR_N-1:0]    mgr_vld,
    input  logic [MGR_N-1:0]    mgr_lck,
    input  logic [MGR_N-1:0]    mgr_wen,
    input  logic [MGR_N*AW-1:0] mgr_adr,
    input  logic [MGR_N*BW-1:0] mgr_ben,
    input  logic [MGR_N*DW-1:0] mgr_wdt,
    output logic [MGR_N-1:0]    mgr_rdy,
    output logic [MGR_N*DW-1:0] mgr_rdt,
    output logic                sub_vld,
    output logic                sub_wen,
    output logic [AW-1:0]       sub_adr,
    output logic [BW-1:0]       sub_ben,
    output logic [DW-1:0]       sub_wdt,
    input  logic                sub_rdy,
    input  logic [DW-1:0]       sub_rdt
);

    logic [MGR_N-1:0] pick_oh;
    logic [IW-1:0]    pick_idx;
    logic [MGR_N-1:0] gnt_oh;
    logic [IW-1:0]    gnt_idx;
    logic             gnt_lck;
    logic             held;
    logic             xfer;

    lockarb_prio #(.MGR_N(MGR_N)) u_prio (
        .req      (mgr_vld),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx)
    );

    lockarb_lock #(.MGR_N(MGR_N)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx),
        .req_lck  (mgr_lck),
        .xfer     (xfer),
        .gnt_oh   (gnt_oh),
        .gnt_idx  (gnt_idx),
        .gnt_lck  (gnt_lck),
        .held     (held)
    );

    always_comb begin
        sub_wen = 1'b0;
        sub_adr = '0;
        sub_ben = '0;
        sub_wdt = '0;
        for (int i = 0; i < MGR_N; i++) begin
            if (gnt_oh[i]) begin
                sub_wen = sub_wen | mgr_wen[i];
                sub_adr = sub_adr | mgr_adr[i*AW +: AW];
                sub_ben = sub_ben | mgr_ben[i*BW +: BW];
                sub_wdt = sub_wdt | mgr_wdt[i*DW +: DW];
            end
        end
        sub_vld = |(mgr_vld & gnt_oh);
        mgr_rdy = gnt_oh & {MGR_N{sub_rdy}};
        xfer    = sub_vld & sub_rdy;
    end

    lockarb_route #(.MGR_N(MGR_N), .DW(DW), .DLY(DLY)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .gnt_idx (gnt_idx),
        .sub_rdt (sub_rdt),
        .mgr_rdt (mgr_rdt)
    );

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mgr_rdy));

    // R3
    rdy_needs_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgr_rdy != '0) |-> sub_rdy);

    // R2
    free_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && mgr_vld != '0) |-> sub_vld);

    // R5
    lock_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && gnt_lck) |=> ((mgr_rdy & ~$past(mgr_rdy)) == '0));

endmodule

// File: tb/lockarb_top_bench.sv
module lockarb_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MGR_N = 3;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int BW    = DW / 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [MGR_N-1:0]    mgr_vld = '0;
    logic [MGR_N-1:0]    mgr_lck = '0;
    logic [MGR_N-1:0]    mgr_wen = '0;
    logic [MGR_N*AW-1:0] mgr_adr = '0;
    logic [MGR_N*BW-1:0] mgr_ben = '0;
    logic [MGR_N*DW-1:0] mgr_wdt = '0;
    logic [MGR_N-1:0]    mgr_rdy;
    logic [MGR_N*DW-1:0] mgr_rdt;
    logic                sub_vld, sub_wen;
    logic [AW-1:0]       sub_adr;
    logic [BW-1:0]       sub_ben;
    logic [DW-1:0]       sub_wdt;
    logic                sub_rdy = 1'b0;
    logic [DW-1:0]       sub_rdt = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockarb_top #(.MGR_N(MGR_N), .AW(AW), .DW(DW), .DLY(1)) u_lockarb_top (
        .clk(clk), .rst_n(rst_n),
        .mgr_vld(mgr_vld), .mgr_lck(mgr_lck), .mgr_wen(mgr_wen),
        .mgr_adr(mgr_adr), .mgr_ben(mgr_ben), .mgr_wdt(mgr_wdt),
        .mgr_rdy(mgr_rdy), .mgr_rdt(mgr_rdt),
        .sub_vld(sub_vld), .sub_wen(sub_wen), .sub_adr(sub_adr),
        .sub_ben(sub_ben), .sub_wdt(sub_wdt),
        .sub_rdy(sub_rdy), .sub_rdt(sub_rdt)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic drive(input int i, input bit v, input bit l, input bit w);
        mgr_vld[i] = v;
        mgr_lck[i] = l;
        mgr_wen[i] = w;
        mgr_adr[i*AW +: AW] = AW'(16'h1000 + 16'(i) * 16'h0111);
        mgr_ben[i*BW +: BW] = BW'(i + 1);
        mgr_wdt[i*DW +: DW] = DW'(32'hA0A0_0000 + 32'(i));
    endtask

    task automatic idle_all();
        for (int i = 0; i < MGR_N; i++) drive(i, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [AW-1:0] exp_adr(input int i);
        return AW'(16'h1000 + 16'(i) * 16'h0111);
    endfunction

    function automatic logic [DW-1:0] exp_wdt(input int i);
        return DW'(32'hA0A0_0000 + 32'(i));
    endfunction

    task automatic t_reset();
        idle_all();
        sub_rdy = 1'b1;
        sub_rdt = 32'hDEAD_BEEF;
        settle();
        chk(sub_vld == 1'b0, "R1 sub_vld", sub_vld, 0);
        chk(mgr_rdy == '0, "R1 mgr_rdy", mgr_rdy, 0);
        chk(mgr_rdt == '0, "R1/R9 mgr_rdt", mgr_rdt, 0);
        tick();
    endtask

    task automatic t_priority();
        idle_all();
        sub_rdy = 1'b1;
        drive(1, 1'b1, 1'b0, 1'b1);
        drive(2, 1'b1, 1'b0, 1'b0);
        settle();
        chk(sub_vld && sub_adr == exp_adr(1), "R2 pair adr", sub_adr, exp_adr(1));
        chk(sub_wen == 1'b1 && sub_ben == 4'd2, "R2 pair wen/ben", {sub_wen, sub_ben}, {1'b1, 4'd2});
        chk(mgr_rdy == 3'b010, "R3 pair rdy", mgr_rdy, 3'b010);
        tick();
        drive(0, 1'b1, 1'b0, 1'b0);
        settle();
        chk(sub_wdt == exp_wdt(0) && sub_wen == 1'b0, "R2 all wdt", sub_wdt, exp_wdt(0));
        chk(mgr_rdy == 3'b001, "R3 all rdy", mgr_rdy, 3'b001);
        tick();
        idle_all();
        drive(2, 1'b1, 1'b0, 1'b0);
        settle();
        chk(sub_adr == exp_adr(2) && mgr_rdy == 3'b100, "R2 single m2", sub_adr, exp_adr(2));
        tick();
        idle_all();
    endtask

    task automatic t_backpressure();
        idle_all();
        sub_rdy = 1'b0;
        drive(1, 1'b1, 1'b1, 1'b0);
        settle();
        chk(sub_vld == 1'b1 && mgr_rdy == '0, "R3/R4 stalled rdy", mgr_rdy, 0);
        tick();
        idle_all();
        drive(0, 1'b1, 1'b0, 1'b0);
        drive(1, 1'b1, 1'b0, 1'b0);
        sub_rdy = 1'b1;
        settle();
        chk(mgr_rdy == 3'b001, "R4 no lock from stall", mgr_rdy, 3'b001);
        tick();
        idle_all();
    endtask

    task automatic t_lock();
        idle_all();
        sub_rdy = 1'b1;
        drive(2, 1'b1, 1'b1, 1'b0);
        settle();
        chk(mgr_rdy == 3'b100, "R5 lock request granted", mgr_rdy, 3'b100);
        tick();
        idle_all();
        drive(0, 1'b1, 1'b0, 1'b0);
        settle();
        chk(sub_vld == 1'b0, "R6 owner idle sub_vld", sub_vld, 0);
        chk(mgr_rdy == 3'b100, "R6 owner idle rdy", mgr_rdy, 3'b100);
        tick();
        settle();
        chk(sub_vld == 1'b0 && mgr_rdy == 3'b100, "R6 second idle cycle", mgr_rdy, 3'b100);
        tick();
        drive(2, 1'b1, 1'b1, 1'b1);
        settle();
        chk(sub_adr == exp_adr(2) && mgr_rdy == 3'b100, "R5 owner over m0", sub_adr, exp_adr(2));
        tick();
        drive(2, 1'b1, 1'b0, 1'b0);
        sub_rdy = 1'b0;
        settle();
        chk(mgr_rdy == '0 && sub_adr == exp_adr(2), "R4 stalled release", sub_adr, exp_adr(2));
        tick();
        sub_rdy = 1'b1;
        settle();
        chk(mgr_rdy == 3'b100, "R4 still held after stall", mgr_rdy, 3'b100);
        tick();
        drive(2, 1'b0, 1'b0, 1'b0);
        settle();
        chk(mgr_rdy == 3'b001 && sub_adr == exp_adr(0), "R7 priority resumes", mgr_rdy, 3'b001);
        tick();
        idle_all();
    endtask

    task automatic t_route();
        idle_all();
        sub_rdy = 1'b1;
        sub_rdt = 32'h5555_0000;
        drive(1, 1'b1, 1'b0, 1'b0);
        tick();
        idle_all();
        drive(0, 1'b1, 1'b0, 1'b1);
        sub_rdt = 32'h1111_0001;
        settle();
        chk(mgr_rdt[1*DW +: DW] == 32'h1111_0001, "R8 m1 response", mgr_rdt[1*DW +: DW], 32'h1111_0001);
        chk(mgr_rdt[0*DW +: DW] == '0 && mgr_rdt[2*DW +: DW] == '0, "R8 others zero", mgr_rdt, 0);
        tick();
        idle_all();
        drive(2, 1'b1, 1'b0, 1'b0);
        sub_rdy = 1'b0;
        sub_rdt = 32'h2222_0000;
        settle();
        chk(mgr_rdt[0*DW +: DW] == 32'h2222_0000, "R10 back-to-back m0", mgr_rdt[0*DW +: DW], 32'h2222_0000);
        chk(mgr_rdt[1*DW +: DW] == '0, "R10 m1 cleared", mgr_rdt[1*DW +: DW], 0);
        tick();
        idle_all();
        sub_rdt = 32'h3333_3333;
        settle();
        chk(mgr_rdt == '0, "R9 after stall", mgr_rdt, 0);
        tick();
        settle();
        chk(mgr_rdt == '0, "R9 after idle", mgr_rdt, 0);
        sub_rdt = '0;
    endtask

    initial begin
        idle_all();
        repeat (2) @(negedge clk);
        settle();
        chk(sub_vld == 1'b0 && mgr_rdy == '0, "R1 in reset", mgr_rdy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_backpressure();
        t_lock();
        t_route();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule